// File: doc/BRIEF.md
# SPI serial memory slave interface

This block is the serial front end of a byte-wide nonvolatile store of 16K bytes. A host talks to it over a four-wire SPI link and may use clock mode 0 or mode 3. The block samples the data-in line on rising SCK and updates the data-out line after falling SCK. Each transfer is framed by an active-low select, and an active-low pause input can freeze a transfer part way through. The block collects an opcode, a 14-bit byte address and any write data. It answers reads by fetching bytes from the store through a simple synchronous byte port.

Writes are collected in a 32-entry page buffer indexed by the low five address bits. They reach the store only when the select is released on a byte boundary, and only if the external protection decision (`allow_write`) permits it. The commit then streams the buffered bytes to the store one per clock. The serial pins are treated as inputs synchronous to `clk` and are oversampled. SCK must stay at each level for at least four `clk` cycles.

Top module: `spi_mem_slave`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `so_en`, `mem_rd` and `mem_wr` are all 0.
- R2: After reset no command is accepted until a high-to-low transition of `cs_n` has been seen; if `cs_n` is already low at reset, clocked bits are ignored (no `so_en`, no `mem_rd`).
- R3: Bits are taken from `si` on rising SCK, MSB first. Byte 1 is the opcode: 0x03 reads and 0x02 writes. Bytes 2 and 3 are the address, high byte first. The upper two bits of the high byte are ignored.
- R4: Read data appears on `so`, MSB first, and `so` changes only after a falling SCK. The first data bit is driven after the falling edge that follows the last address bit.
- R5: While `cs_n` is high, `so_en` is 0 and the interface is idle.
- R6: Successive read bytes come from incrementing addresses across the whole array; after 0x3FFF the next byte comes from 0x0000.
- R7: Write bytes fill the page buffer at the column given by address bits 4:0. The column advances modulo 32 and the upper address bits stay fixed, so a 33rd byte overwrites the first.
- R8: A write reaches the store only when `cs_n` rises after a whole number of data bytes. The buffered columns are then written in ascending column order, one per `mem_wr` cycle. If `cs_n` rises mid-byte, the whole write is discarded.
- R9: If `allow_write` is low when `cs_n` rises, the buffered write is discarded.
- R10: An opcode that completes while `mem_busy` is high (or while a commit is running) is ignored for the rest of that select.
- R11: `hold_n` low, taken while SCK is low, makes the block ignore SCK and `si` and drop `so_en`. The partial command is kept, and the transfer resumes exactly where it paused once `hold_n` is high again with SCK low.
- R12: A change of `hold_n` while SCK is high takes effect only once SCK is low.
- R13: Any opcode other than 0x03 or 0x02 is ignored until the next select.
- R14: Reads and writes work identically with SCK idling low (mode 0) or high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | Drive enable for `so`; low means high impedance |
| mem_addr | output | 14 | Byte address to the store |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` the next cycle |
| mem_rdata | input | 8 | Read data from the store |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data to the store |
| mem_busy | input | 1 | Store is busy with an internal write |
| allow_write | input | 1 | Protection decision; writes commit only when high |

## Verification
The hardest case to reach is a pause that lands in the middle of a byte and is then released while SCK is high. Here the bit counter and the output bit must both survive stray SCK and SI activity. The bench drives this through its byte-transfer task, which can stop at a chosen bit, toggle SCK and SI while the pause is active, and raise SCK before releasing `hold_n`. It then checks that `so_en` stays low until SCK falls and that the interrupted byte still reads back correctly. Page-buffer wrap-around is reached with a 33-byte write that starts two columns before the end of a page, and mid-byte discard with a select released three bits into a data byte.

// File: rtl/spi_mem_pkg.sv
// Shared types and command codes for the SPI serial memory slave.
package spi_mem_pkg;

    // Phases of one selected transfer.
    typedef enum logic [2:0] {
        PH_IDLE,   // not selected, or waiting for a select edge
        PH_OPC,    // shifting in the command byte
        PH_ADH,    // shifting in the high address byte
        PH_ADL,    // shifting in the low address byte
        PH_RD,     // streaming read data out
        PH_WR,     // collecting write data
        PH_SKIP    // command rejected, wait for deselect
    } phase_t;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

endpackage

// File: rtl/spi_mem_pins.sv
// Serial pin conditioning: registers the SPI pins into the clk domain,
// turns SCK and select transitions into one-cycle events and tracks the
// pause state. Assumes the pins are already synchronous to clk and that
// SCK holds each level for several clk cycles.
module spi_mem_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic cs_hi,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_bit,
    output logic held
);

    logic sck_q, sck_p, cs_p, hold_q;

    // Sample the pins and keep the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            sck_p  <= 1'b0;
            cs_hi  <= 1'b0;
            cs_p   <= 1'b0;
            si_bit <= 1'b0;
            hold_q <= 1'b1;
        end else begin
            sck_q  <= sck;
            sck_p  <= sck_q;
            cs_hi  <= cs_n;
            cs_p   <= cs_hi;
            si_bit <= si;
            hold_q <= hold_n;
        end
    end

    // Pause state follows hold_n only while SCK is low.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= 1'b0;
        else if (!sck_q) held <= !hold_q;
    end

    assign cs_fall  = cs_p & ~cs_hi;
    assign cs_rise  = ~cs_p & cs_hi;
    assign sck_rise = ~sck_p & sck_q & ~held;
    assign sck_fall = sck_p & ~sck_q & ~held;

    a_r12_hold_level_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        sck_q |=> $stable(held));

endmodule

// File: rtl/spi_mem_page_buf.sv
// Page write buffer: keeps one byte per column of a page plus a valid
// bit, and on commit writes each valid column to the store in ascending
// order, one per cycle. Assumes PAGE_BYTES is a power of two and that no
// new write data arrives during the PAGE_BYTES-cycle commit.
module spi_mem_page_buf #(
    parameter int ADDR_W     = 14,
    parameter int PAGE_BYTES = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clear,
    input  logic                              we,
    input  logic [$clog2(PAGE_BYTES)-1:0]     wcol,
    input  logic [7:0]                        wdata,
    input  logic                              commit,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
    output logic                              busy,
    output logic                              mem_wr,
    output logic [ADDR_W-1:0]                 mem_waddr,
    output logic [7:0]                        mem_wdata
);

    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - COL_W;
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

    logic [7:0]            slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;
    logic [COL_W-1:0]      scan_q;
    logic [PAGE_W-1:0]     page_q;
    logic                  run_q;

    // Data storage: the latest byte for a column replaces the older one.
    always_ff @(posedge clk) begin
        if (we) slot_q[wcol] <= wdata;
    end

    // Valid bits and the commit scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            scan_q <= '0;
            page_q <= '0;
            run_q  <= 1'b0;
        end else if (run_q) begin
            scan_q <= scan_q + 1'b1;
            if (scan_q == LAST_COL) begin
                run_q <= 1'b0;
                vld_q <= '0;
            end
        end else if (commit) begin
            run_q  <= 1'b1;
            scan_q <= '0;
            page_q <= page;
        end else if (clear) begin
            vld_q <= '0;
        end else if (we) begin
            vld_q[wcol] <= 1'b1;
        end
    end

    assign busy      = run_q;
    assign mem_wr    = run_q & vld_q[scan_q];
    assign mem_waddr = {page_q, scan_q};
    assign mem_wdata = slot_q[scan_q];

    a_r8_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !run_q);

endmodule

// File: rtl/spi_mem_slave.sv
// SPI serial memory slave front end. Decodes read and write commands
// framed by cs_n, streams read data from the store with address
// auto-increment and collects write data in a page buffer that is
// committed on a byte-aligned deselect. Assumes SCK half periods of at
// least four clk cycles and a store that returns read data one cycle
// after mem_rd.
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int PAGE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_busy,
    input  logic              allow_write
);

    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int HI_W  = ADDR_W - 8;

    logic cs_hi, cs_fall, cs_rise, sck_rise, sck_fall, si_bit, held;

    phase_t            phase;
    logic [2:0]        bit_cnt;
    logic [6:0]        in_sh;
    logic              is_wr;
    logic [ADDR_W-1:0] addr_q;
    logic [COL_W-1:0]  col_q;
    logic              rd_req, load_pend;
    logic [7:0]        obyte;
    logic              so_q;

    logic [7:0]        byte_in;
    logic              byte_done, busy_any, wr_busy;
    logic              buf_clear, buf_we, commit;
    logic [ADDR_W-1:0] waddr;

    spi_mem_pins u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .cs_n    (cs_n),
        .si      (si),
        .hold_n  (hold_n),
        .cs_hi   (cs_hi),
        .cs_fall (cs_fall),
        .cs_rise (cs_rise),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .si_bit  (si_bit),
        .held    (held)
    );

    assign byte_in   = {in_sh, si_bit};
    assign byte_done = sck_rise & ~cs_hi & ~cs_fall & (phase != PH_IDLE) & (bit_cnt == 3'd7);
    assign busy_any  = mem_busy | wr_busy;
    assign buf_clear = byte_done & (phase == PH_ADL) & is_wr;
    assign buf_we    = byte_done & (phase == PH_WR);
    assign commit    = cs_rise & (phase == PH_WR) & (bit_cnt == 3'd0) & allow_write;

    spi_mem_page_buf #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (buf_clear),
        .we       (buf_we),
        .wcol     (col_q),
        .wdata    (byte_in),
        .commit   (commit),
        .page     (addr_q[ADDR_W-1:COL_W]),
        .busy     (wr_busy),
        .mem_wr   (mem_wr),
        .mem_waddr(waddr),
        .mem_wdata(mem_wdata)
    );

    // Command framing: phase, bit count, address and column tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            in_sh   <= '0;
            is_wr   <= 1'b0;
            addr_q  <= '0;
            col_q   <= '0;
            rd_req  <= 1'b0;
        end else begin
            rd_req <= 1'b0;
            if (cs_fall) begin
                phase   <= PH_OPC;
                bit_cnt <= '0;
            end else if (cs_hi) begin
                phase <= PH_IDLE;
            end else if (sck_rise && phase != PH_IDLE) begin
                bit_cnt <= bit_cnt + 3'd1;
                in_sh   <= byte_in[6:0];
                if (bit_cnt == 3'd7) begin
                    case (phase)
                        PH_OPC: begin
                            if (busy_any) phase <= PH_SKIP;
                            else if (byte_in == OP_READ) begin
                                phase <= PH_ADH;
                                is_wr <= 1'b0;
                            end else if (byte_in == OP_WRITE) begin
                                phase <= PH_ADH;
                                is_wr <= 1'b1;
                            end else phase <= PH_SKIP;
                        end
                        PH_ADH: begin
                            addr_q[ADDR_W-1:8] <= byte_in[HI_W-1:0];
                            phase <= PH_ADL;
                        end
                        PH_ADL: begin
                            addr_q[7:0] <= byte_in;
                            col_q       <= byte_in[COL_W-1:0];
                            if (is_wr) phase <= PH_WR;
                            else begin
                                phase  <= PH_RD;
                                rd_req <= 1'b1;
                            end
                        end
                        PH_RD: begin
                            addr_q <= addr_q + 1'b1;
                            rd_req <= 1'b1;
                        end
                        PH_WR: col_q <= col_q + 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    // Read path: capture fetched bytes and shift bits out on falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_pend <= 1'b0;
            obyte     <= '0;
            so_q      <= 1'b0;
        end else begin
            load_pend <= rd_req;
            if (load_pend) obyte <= mem_rdata;
            if (sck_fall && !cs_hi && phase == PH_RD) so_q <= obyte[3'd7 - bit_cnt];
        end
    end

    assign so       = so_q;
    assign so_en    = (phase == PH_RD) & ~cs_hi & ~held;
    assign mem_rd   = rd_req;
    assign mem_addr = wr_busy ? waddr : addr_q;

    a_r5_deselect_floats: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> !so_en);

    a_r4_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so));

    a_r11_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cs_fall && !cs_hi) |=> ($stable(bit_cnt) && $stable(phase)));

    a_r2_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !cs_fall) |=> (phase == PH_IDLE));

    a_r10_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic mem_busy = 1'b0, allow_write = 1'b1;
    logic [7:0] mem_rdata = 8'h00;
    logic so, so_en, mem_rd, mem_wr;
    logic [13:0] mem_addr;
    logic [7:0] mem_wdata;

    int vec = 0, mis = 0, rd_cnt = 0, wr_cnt = 0;
    bit mode3 = 1'b0;
    bit done = 1'b0;
    logic [7:0] store [int];
    logic [21:0] exp_q [$];

    always #2 clk = ~clk;

    spi_mem_slave dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_en(so_en), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_busy(mem_busy), .allow_write(allow_write)
    );

    function automatic logic [7:0] peek(int a);
        if (store.exists(a)) return store[a];
        return 8'((a * 7) ^ (a >> 8) ^ 8'h5A);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        vec++;
        if (act !== exp) begin
            mis++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Store model and write scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && mem_rd) begin
            rd_cnt++;
            mem_rdata <= peek(int'(mem_addr));
        end
        if (rst_n && mem_wr) begin
            wr_cnt++;
            if (exp_q.size() == 0) begin
                mis++; vec++;
                $display("FAIL R8 unexpected write: actual %0h@%0h expected none", mem_wdata, mem_addr);
            end else begin
                logic [21:0] e;
                e = exp_q.pop_front();
                check("R8", {mem_addr, mem_wdata}, {10'd0, e}, "commit addr/data");
            end
            store[int'(mem_addr)] = mem_wdata;
        end
    end

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_hold(input int hk);
        hw(2);
        hold_n = 1'b0;
        hw(4);
        check("R11", so_en, 0, "so_en during pause");
        repeat (3) begin
            sck = 1'b1; si = ~si; hw(4);
            sck = 1'b0; hw(4);
        end
        if (hk == 1) begin
            sck = 1'b1; hw(4);
            hold_n = 1'b1; hw(4);
            check("R12", so_en, 0, "release with SCK high still paused");
            sck = 1'b0; hw(4);
        end else begin
            hold_n = 1'b1; hw(4);
        end
    endtask

    task automatic xbyte(input logic [7:0] d, input int hat, input int hk, output logic [7:0] q, output int en);
        en = 0;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = d[i];
            if (hat == i) begin
                do_hold(hk);
                si = d[i];
            end
            hw(H);
            q[i] = so;
            en += int'(so_en);
            sck = 1'b1;
            hw(H);
        end
    endtask

    task automatic begin_cmd();
        sck = mode3; hw(H);
        cs_n = 1'b0; hw(H);
    endtask

    task automatic end_cmd();
        if (!mode3) begin sck = 1'b0; hw(H); end
        cs_n = 1'b1; hw(H);
        check("R5", so_en, 0, "so_en with select high");
        hw(48);
    endtask

    // Read: op, address, n data bytes; hold may be injected at byte hb bit hbit.
    task automatic do_read(input logic [7:0] op, input logic [7:0] ah, input logic [7:0] al, input int n,
                           input bit ok, input int hb, input int hbit, input int hk, input string req);
        logic [7:0] q, cmd [3];
        int en, a, r0;
        cmd[0] = op; cmd[1] = ah; cmd[2] = al;
        a = int'({ah[5:0], al});
        r0 = rd_cnt;
        begin_cmd();
        for (int j = 0; j < 3; j++) xbyte(cmd[j], (hb == j) ? hbit : -1, hk, q, en);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, (hb == k + 3) ? hbit : -1, hk, q, en);
            if (ok) begin
                check(req, q, peek(a), "read byte");
                check(req, en, 8, "so_en during data");
            end else check(req, en, 0, "rejected: so_en");
            a = (a + 1) & 16'h3FFF;
        end
        end_cmd();
        if (!ok) check(req, rd_cnt - r0, 0, "rejected: mem_rd pulses");
    endtask

    // Write: n bytes plus cut extra bits; expected commits pushed when valid.
    task automatic do_write(input logic [7:0] ah, input logic [7:0] al, input int n, input int cut,
                            input bit expect_commit, input int seed, input string req);
        logic [7:0] q, d, pb [32];
        bit vld [32];
        int en, w0, nexp;
        logic [4:0] col;
        for (int i = 0; i < 32; i++) vld[i] = 1'b0;
        col = al[4:0];
        w0 = wr_cnt; nexp = 0;
        begin_cmd();
        xbyte(8'h02, -1, 0, q, en);
        xbyte(ah, -1, 0, q, en);
        xbyte(al, -1, 0, q, en);
        for (int k = 0; k < n; k++) begin
            d = 8'(seed + k * 37);
            xbyte(d, -1, 0, q, en);
            pb[col] = d; vld[col] = 1'b1; col = col + 5'd1;
        end
        for (int i = 0; i < cut; i++) begin
            sck = 1'b0; si = 1'b1; hw(H);
            sck = 1'b1; hw(H);
        end
        if (expect_commit)
            for (int i = 0; i < 32; i++)
                if (vld[i]) begin
                    exp_q.push_back({ah[5:0], al[7:5], 5'(i), pb[i]});
                    nexp++;
                end
        end_cmd();
        check(req, exp_q.size(), 0, "expected commits drained");
        check(req, wr_cnt - w0, nexp, "mem_wr count");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mis++; vec++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        int en, tot;
        hw(6);
        check("R1", {so_en, mem_rd, mem_wr}, 0, "outputs in reset");
        rst_n = 1'b1;
        hw(2);
        check("R1", {so_en, mem_rd, mem_wr}, 0, "outputs after reset");
        // R2: select already low at reset, no fall seen
        tot = 0;
        xbyte(8'h03, -1, 0, q, en); tot += en;
        xbyte(8'h00, -1, 0, q, en); tot += en;
        xbyte(8'h10, -1, 0, q, en); tot += en;
        xbyte(8'h00, -1, 0, q, en); tot += en;
        check("R2", tot, 0, "so_en without select edge");
        check("R2", rd_cnt, 0, "mem_rd without select edge");
        sck = 1'b0; cs_n = 1'b1; hw(H);
        check("R5", so_en, 0, "idle so_en");

        // R3, R4: mode 0 read
        do_read(8'h03, 8'h00, 8'h10, 4, 1, -1, -1, 0, "R4");
        // R3, R8: write then read back
        do_write(8'h01, 8'h23, 3, 0, 1, 8'h11, "R8");
        do_read(8'h03, 8'h01, 8'h23, 3, 1, -1, -1, 0, "R3");
        // R7: page wrap with 33 bytes from column 30
        do_write(8'h02, 8'hFE, 33, 0, 1, 8'h40, "R7");
        do_read(8'h03, 8'h02, 8'hE0, 32, 1, -1, -1, 0, "R7");
        // R8: select released mid-byte
        do_write(8'h04, 8'h00, 2, 3, 0, 8'h77, "R8");
        do_read(8'h03, 8'h04, 8'h00, 2, 1, -1, -1, 0, "R8");
        // R9: protection refuses the write
        allow_write = 1'b0;
        do_write(8'h05, 8'h00, 2, 0, 0, 8'h99, "R9");
        allow_write = 1'b1;
        do_read(8'h03, 8'h05, 8'h00, 2, 1, -1, -1, 0, "R9");
        // R10: store busy
        mem_busy = 1'b1;
        do_read(8'h03, 8'h00, 8'h20, 2, 0, -1, -1, 0, "R10");
        do_write(8'h06, 8'h00, 1, 0, 0, 8'h22, "R10");
        mem_busy = 1'b0;
        // R13: unknown opcode
        do_read(8'h05, 8'h00, 8'h30, 2, 0, -1, -1, 0, "R13");
        check("R13", wr_cnt, 35, "no write from unknown opcode");
        // R6: wrap at the top, upper address bits ignored (0xFF -> 0x3F)
        do_read(8'h03, 8'hFF, 8'hFE, 3, 1, -1, -1, 0, "R6");
        // R11: pause in opcode and in data; R12: release while SCK high
        do_read(8'h03, 8'h00, 8'h40, 2, 1, 0, 4, 0, "R11");
        do_read(8'h03, 8'h00, 8'h50, 2, 1, 3, 3, 0, "R11");
        do_read(8'h03, 8'h00, 8'h60, 2, 1, 4, 5, 1, "R12");
        // R14: mode 3
        mode3 = 1'b1;
        do_write(8'h07, 8'h1F, 2, 0, 1, 8'h3C, "R14");
        do_read(8'h03, 8'h07, 8'h1E, 3, 1, -1, -1, 0, "R14");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    end

endmodule